// File: doc/BRIEF.md
# Reservation Station Array with Reorder-Buffer Tags

This block holds a small set of waiting instructions for an out-of-order core. At dispatch an instruction is written into a free slot. Each slot holds an opcode, a destination tag and two source operands. The destination tag is the reorder-buffer index that was allocated to the instruction. Each source either carries its value already, shown by a source tag of zero, or names the reorder-buffer index of the instruction that will produce it.

The array watches a single result bus that carries a value and its tag. Any waiting source whose tag matches the bus picks up the value and becomes ready. When a slot has both sources ready it is offered for issue. When a functional unit accepts it, the slot is released at once. Because destination tags are reorder-buffer indices rather than slot numbers, the slot never waits for its own result broadcast. A flush input empties the whole array in one cycle.

Each slot is a three-state machine:
- `ST_FREE`: the slot is empty.
- `ST_WAIT`: the slot is occupied and at least one source is unresolved.
- `ST_RDY`: the slot is occupied and both sources are resolved.

Transitions:
- alloc: `ST_FREE` to `ST_WAIT`, or straight to `ST_RDY` when both sources are already resolved.
- wake: `ST_WAIT` to `ST_RDY` when the last missing source is captured.
- issue: `ST_RDY` to `ST_FREE`.
- flush: any state to `ST_FREE`.

Top module: `rs_array`

## Requirements
- R1: After reset every slot is free, `disp_full` is low and `iss_valid` is low.
- R2: A dispatch with `disp_valid` high while `disp_full` is low is written into the lowest-numbered free slot. The slot is occupied from the next clock edge.
- R3: `disp_full` is high exactly when all slots are occupied. A dispatch presented while `disp_full` is high is dropped and never issues.
- R4: A source whose tag is 0 is taken as ready, holding the value supplied with it. Tag 0 is reserved and never names a producer.
- R5: When `bus_valid` is high and `bus_tag` is nonzero, every occupied slot whose unresolved source tag equals `bus_tag` stores `bus_value` in that source. That source is resolved from the next edge.
- R6: A bus broadcast in the same cycle as a dispatch whose source tag equals `bus_tag` is captured by the newly written slot.
- R7: `iss_valid` is high when any slot is ready. `iss_idx`, `iss_op`, `iss_dst`, `iss_v1` and `iss_v2` then show the lowest-numbered ready slot. At most one slot issues per cycle.
- R8: A slot is freed at the edge where `iss_valid` and `iss_en` are both high. This happens without any broadcast of its own destination tag.
- R9: `flush` frees every slot at the next edge. A dispatch in the same cycle is dropped.
- R10: A bus cycle with `bus_valid` low, or with `bus_tag` equal to 0, resolves no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all slots |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Reorder-buffer index of the instruction |
| disp_t1 | input | TAG_W | Producer tag of source 1, 0 when ready |
| disp_v1 | input | DATA_W | Value of source 1 when its tag is 0 |
| disp_t2 | input | TAG_W | Producer tag of source 2, 0 when ready |
| disp_v2 | input | DATA_W | Value of source 2 when its tag is 0 |
| disp_full | output | 1 | All slots occupied; dispatch must stall |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_value | input | DATA_W | Broadcast result value |
| iss_en | input | 1 | Functional unit accepts the offered slot |
| iss_valid | output | 1 | A ready slot is offered |
| iss_idx | output | IDX_W | Index of the offered slot |
| iss_op | output | OP_W | Opcode of the offered slot |
| iss_dst | output | TAG_W | Destination tag of the offered slot |
| iss_v1 | output | DATA_W | Source 1 value of the offered slot |
| iss_v2 | output | DATA_W | Source 2 value of the offered slot |

## Verification
Directed patterns are used first, each aimed at one behaviour:
- Sources that arrive already ready separate alloc-to-ready from alloc-to-wait.
- Filling every slot and then pushing one more dispatch shows whether a stalled request leaks in.
- Broadcasts with tag zero, or with valid low, separate real wakes from spurious ones.
- A broadcast that lines up with a dispatch exposes a missing bypass.
- Several ready slots issued in a row check the lowest-index order and the immediate release.

A long random phase then mixes dispatch, wake, issue and occasional flush. In that phase a behavioural model is compared against the design on every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RDY  = 2'd2
    } rs_state_e;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest index wins: scan downwards so the last hit is the lowest
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [OP_W-1:0]   a_op,
    input  logic [TAG_W-1:0]  a_dst,
    input  logic [TAG_W-1:0]  a_t1,
    input  logic [DATA_W-1:0] a_v1,
    input  logic [TAG_W-1:0]  a_t2,
    input  logic [DATA_W-1:0] a_v2,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   e_op,
    output logic [TAG_W-1:0]  e_dst,
    output logic [DATA_W-1:0] e_v1,
    output logic [DATA_W-1:0] e_v2
);
    rs_state_e         state_q, state_d;
    logic [OP_W-1:0]   op_q, op_d;
    logic [TAG_W-1:0]  dst_q, dst_d, t1_q, t1_d, t2_q, t2_d;
    logic [DATA_W-1:0] v1_q, v1_d, v2_q, v2_d;
    logic              hit;

    assign hit = bus_valid && (bus_tag != '0);

    // operand fields: load at alloc (with bus bypass), else snoop the bus
    always_comb begin
        op_d  = op_q;
        dst_d = dst_q;
        t1_d  = t1_q;
        t2_d  = t2_q;
        v1_d  = v1_q;
        v2_d  = v2_q;
        if (alloc) begin
            op_d  = a_op;
            dst_d = a_dst;
            if (hit && a_t1 != '0 && a_t1 == bus_tag) begin
                t1_d = '0;
                v1_d = bus_value;
            end else begin
                t1_d = a_t1;
                v1_d = a_v1;
            end
            if (hit && a_t2 != '0 && a_t2 == bus_tag) begin
                t2_d = '0;
                v2_d = bus_value;
            end else begin
                t2_d = a_t2;
                v2_d = a_v2;
            end
        end else begin
            if (hit && t1_q != '0 && t1_q == bus_tag) begin
                t1_d = '0;
                v1_d = bus_value;
            end
            if (hit && t2_q != '0 && t2_q == bus_tag) begin
                t2_d = '0;
                v2_d = bus_value;
            end
        end
    end

    // slot state machine: alloc, wake, issue, flush
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (alloc) state_d = (t1_d == '0 && t2_d == '0) ? ST_RDY : ST_WAIT;
            ST_WAIT: if (t1_d == '0 && t2_d == '0) state_d = ST_RDY;
            ST_RDY:  if (grant) state_d = ST_FREE;
            default: state_d = ST_FREE;
        endcase
        if (flush) state_d = ST_FREE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            dst_q <= '0;
            t1_q  <= '0;
            t2_q  <= '0;
            v1_q  <= '0;
            v2_q  <= '0;
        end else begin
            op_q  <= op_d;
            dst_q <= dst_d;
            t1_q  <= t1_d;
            t2_q  <= t2_d;
            v1_q  <= v1_d;
            v2_q  <= v2_d;
        end
    end

    // outputs
    always_comb begin
        busy  = (state_q != ST_FREE);
        ready = (state_q == ST_RDY);
        e_op  = op_q;
        e_dst = dst_q;
        e_v1  = v1_q;
        e_v2  = v2_q;
    end

    AST_WAKE_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && t1_q != '0 && bus_valid && bus_tag == t1_q && !flush)
        |=> (t1_q == '0 && v1_q == $past(bus_value))); // R5
    AST_BYPASS_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && a_t2 != '0 && bus_valid && bus_tag == a_t2)
        |=> (t2_q == '0 && v2_q == $past(bus_value))); // R6
    AST_FREE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !busy); // R8
    AST_NO_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !(bus_valid && bus_tag != '0) && !alloc && !flush)
        |=> ($stable(t1_q) && $stable(t2_q))); // R10
endmodule

// File: rtl/rs_array.sv
module rs_array #(
    parameter int N_ENT  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic [TAG_W-1:0]  disp_t1,
    input  logic [DATA_W-1:0] disp_v1,
    input  logic [TAG_W-1:0]  disp_t2,
    input  logic [DATA_W-1:0] disp_v2,
    output logic              disp_full,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              iss_en,
    output logic              iss_valid,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_v1,
    output logic [DATA_W-1:0] iss_v2
);
    logic [N_ENT-1:0]  busy_vec, ready_vec, free_gnt, iss_gnt, alloc_vec, grant_vec;
    logic              free_any, alloc_fire, iss_fire;
    logic [IDX_W-1:0]  free_idx;
    logic [OP_W-1:0]   e_op  [N_ENT];
    logic [TAG_W-1:0]  e_dst [N_ENT];
    logic [DATA_W-1:0] e_v1  [N_ENT];
    logic [DATA_W-1:0] e_v2  [N_ENT];

    rs_pick #(.N(N_ENT), .IW(IDX_W)) i_free_pick (
        .req(~busy_vec), .gnt(free_gnt), .any(free_any), .idx(free_idx)
    );

    rs_pick #(.N(N_ENT), .IW(IDX_W)) i_iss_pick (
        .req(ready_vec), .gnt(iss_gnt), .any(iss_valid), .idx(iss_idx)
    );

    assign disp_full  = !free_any;
    assign alloc_fire = disp_valid && free_any && !flush;
    assign iss_fire   = iss_valid && iss_en;
    assign alloc_vec  = free_gnt & {N_ENT{alloc_fire}};
    assign grant_vec  = iss_gnt & {N_ENT{iss_fire}};

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) i_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .alloc(alloc_vec[g]),
            .a_op(disp_op), .a_dst(disp_dst),
            .a_t1(disp_t1), .a_v1(disp_v1), .a_t2(disp_t2), .a_v2(disp_v2),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
            .grant(grant_vec[g]),
            .busy(busy_vec[g]), .ready(ready_vec[g]),
            .e_op(e_op[g]), .e_dst(e_dst[g]), .e_v1(e_v1[g]), .e_v2(e_v2[g])
        );
    end

    assign iss_op  = e_op[iss_idx];
    assign iss_dst = e_dst[iss_idx];
    assign iss_v1  = e_v1[iss_idx];
    assign iss_v2  = e_v2[iss_idx];

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_vec == '0)); // R9
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_full && disp_valid && !flush && !iss_fire)
        |=> (busy_vec == $past(busy_vec))); // R3
    AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_gnt)); // R7
    AST_ISSUE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (ready_vec[iss_idx]
                       && ((ready_vec & ((N_ENT'(1) << iss_idx) - N_ENT'(1))) == '0))); // R7
endmodule

// File: tb/test_rs_array.sv
module test_rs_array;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic [3:0]  disp_op = '0;
    logic [3:0]  disp_dst = '0;
    logic [3:0]  disp_t1 = '0;
    logic [15:0] disp_v1 = '0;
    logic [3:0]  disp_t2 = '0;
    logic [15:0] disp_v2 = '0;
    logic        disp_full;
    logic        bus_valid = 1'b0;
    logic [3:0]  bus_tag = '0;
    logic [15:0] bus_value = '0;
    logic        iss_en = 1'b0;
    logic        iss_valid;
    logic [1:0]  iss_idx;
    logic [3:0]  iss_op;
    logic [3:0]  iss_dst;
    logic [15:0] iss_v1;
    logic [15:0] iss_v2;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    ended = 0;
    string cur_req = "R1";

    // behavioural model state
    bit m_busy [N];
    int m_op [N], m_dst [N], m_t1 [N], m_t2 [N], m_v1 [N], m_v2 [N];

    rs_array i_rs_array (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_t1(disp_t1), .disp_v1(disp_v1), .disp_t2(disp_t2), .disp_v2(disp_v2),
        .disp_full(disp_full),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .iss_en(iss_en), .iss_valid(iss_valid), .iss_idx(iss_idx),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_v1(iss_v1), .iss_v2(iss_v2)
    );

    always #10 clk = ~clk;

    function automatic int first_ready();
        for (int i = 0; i < N; i++)
            if (m_busy[i] && m_t1[i] == 0 && m_t2[i] == 0) return i;
        return -1;
    endfunction

    function automatic int first_free();
        for (int i = 0; i < N; i++)
            if (!m_busy[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_busy[i] = 0;
                m_t1[i] = 0;
                m_t2[i] = 0;
            end
        end else begin
            int iss, fr;
            iss = first_ready();
            fr  = first_free();
            if (flush) begin
                for (int i = 0; i < N; i++) m_busy[i] = 0;
            end else begin
                if (iss >= 0 && iss_en) m_busy[iss] = 0;
                if (bus_valid && bus_tag != 0) begin
                    for (int i = 0; i < N; i++) begin
                        if (m_busy[i] && m_t1[i] == int'(bus_tag)) begin
                            m_t1[i] = 0;
                            m_v1[i] = int'(bus_value);
                        end
                        if (m_busy[i] && m_t2[i] == int'(bus_tag)) begin
                            m_t2[i] = 0;
                            m_v2[i] = int'(bus_value);
                        end
                    end
                end
                if (disp_valid && fr >= 0) begin
                    m_busy[fr] = 1;
                    m_op[fr]   = int'(disp_op);
                    m_dst[fr]  = int'(disp_dst);
                    m_t1[fr]   = int'(disp_t1);
                    m_v1[fr]   = int'(disp_v1);
                    m_t2[fr]   = int'(disp_t2);
                    m_v2[fr]   = int'(disp_v2);
                    if (bus_valid && bus_tag != 0 && disp_t1 == bus_tag) begin
                        m_t1[fr] = 0;
                        m_v1[fr] = int'(bus_value);
                    end
                    if (bus_valid && bus_tag != 0 && disp_t2 == bus_tag) begin
                        m_t2[fr] = 0;
                        m_v2[fr] = int'(bus_value);
                    end
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // compare on every falling edge; outputs depend only on state
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            int e;
            e = first_ready();
            check("disp_full", int'(disp_full), (first_free() < 0) ? 1 : 0);
            check("iss_valid", int'(iss_valid), (e >= 0) ? 1 : 0);
            if (e >= 0) begin
                check("iss_idx", int'(iss_idx), e);
                check("iss_op",  int'(iss_op),  m_op[e]);
                check("iss_dst", int'(iss_dst), m_dst[e]);
                check("iss_v1",  int'(iss_v1),  m_v1[e]);
                check("iss_v2",  int'(iss_v2),  m_v2[e]);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic disp(int op, int dst, int t1, int v1, int t2, int v2);
        disp_valid = 1'b1;
        disp_op = 4'(op); disp_dst = 4'(dst);
        disp_t1 = 4'(t1); disp_v1 = 16'(v1);
        disp_t2 = 4'(t2); disp_v2 = 16'(v2);
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic bcast(bit vld, int tag, int val);
        bus_valid = vld; bus_tag = 4'(tag); bus_value = 16'(val);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        cur_req = "R1";
        idle(2);
        cur_req = "R4";                 // both sources ready at dispatch
        disp(1, 1, 0, 10, 0, 20);
        idle(1);
        cur_req = "R2";                 // fill next lowest slots, waiting
        disp(2, 2, 3, 0, 0, 5);
        disp(3, 3, 0, 7, 4, 0);
        idle(1);
        cur_req = "R3";                 // last slot, then a dropped dispatch
        disp(4, 4, 5, 0, 6, 0);
        disp(5, 5, 0, 1, 0, 2);
        idle(1);
        cur_req = "R10";                // tag-zero and invalid broadcasts
        bcast(1'b1, 0, 99);
        bcast(1'b0, 3, 98);
        idle(1);
        cur_req = "R5";
        bcast(1'b1, 3, 33);
        bcast(1'b1, 4, 44);
        idle(1);
        cur_req = "R7";                 // drain ready slots in index order
        iss_en = 1'b1;
        idle(3);
        iss_en = 1'b0;
        cur_req = "R8";
        bcast(1'b1, 5, 55);
        bcast(1'b1, 6, 66);
        iss_en = 1'b1;
        idle(2);
        iss_en = 1'b0;
        cur_req = "R6";                 // bypass on both sources
        bus_valid = 1'b1; bus_tag = 4'd8; bus_value = 16'd88;
        disp(6, 9, 8, 0, 8, 0);
        bus_valid = 1'b0;
        idle(2);
        cur_req = "R9";                 // flush with a dispatch alongside
        disp(7, 10, 11, 0, 0, 3);
        flush = 1'b1;
        disp(8, 12, 0, 1, 0, 2);
        flush = 1'b0;
        idle(2);
        cur_req = "R7";                 // random mix
        for (int k = 0; k < 600; k++) begin
            disp_valid = ($urandom % 2) == 0;
            disp_op  = 4'($urandom % 16);
            disp_dst = 4'(1 + $urandom % 7);
            disp_t1  = 4'($urandom % 8);
            disp_v1  = 16'($urandom);
            disp_t2  = 4'($urandom % 8);
            disp_v2  = 16'($urandom);
            bus_valid = ($urandom % 2) == 0;
            bus_tag   = 4'($urandom % 8);
            bus_value = 16'($urandom);
            iss_en    = ($urandom % 3) != 0;
            flush     = ($urandom % 40) == 0;
            @(negedge clk);
        end
        disp_valid = 1'b0; bus_valid = 1'b0; iss_en = 1'b0; flush = 1'b0;
        idle(2);
        finish_run();
    end
endmodule